// File: doc/BRIEF.md
# Three-Port Parallel I/O Interface

This block is a small programmable parallel interface for a processor bus. It has three byte-wide ports, A, B and C, and a command register. All four are reached through a 2-bit register address, an active-low chip select and separate active-low read and write strobes. Port C is split into two nibbles. The upper nibble belongs with port A and the lower nibble with port B, and each nibble has its own direction.

Software writes a command word to set which ports, or nibbles, drive their pins and which only sense them. A port set as output holds the last value written to it and drives it out, with a per-bit output enable to control the pad. A port set as input returns the live pin value when read. Reset leaves everything as inputs, so no pin is driven until software asks for it. Writes take effect on the rising clock edge. Reads are combinational from the address and strobes.

Top module: `triport_pio`

## Requirements
- R1: Register address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the command register. A write happens on a rising clock edge only while cs_n and wr_n are both low. A write strobe with cs_n high changes nothing.
- R2: After reset every port is an input: all output enables are 0 and all output latches are 0.
- R3: A command write whose bit 7 is 1 sets the directions, with 1 meaning input: bit 4 for port A, bit 3 for port C bits 7..4, bit 1 for port B and bit 0 for port C bits 3..0. Its other bits have no effect.
- R4: Every command write with bit 7 set clears all three output latches to zero.
- R5: A command write with bit 7 clear changes neither the directions nor the latches.
- R6: A port write stores the data only into bits configured as output. Bits configured as input keep their latch value.
- R7: Reading a port returns the pin input for bits configured as input and the latch for bits configured as output. Port C is handled nibble by nibble.
- R8: Reading the command register returns 00h.
- R9: rdata is 00h whenever cs_n or rd_n is high.
- R10: Each output enable bit is 1 exactly when its bit is configured as output. pin_x_out always shows the latch of port x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wdata | input | W | Write data from the processor |
| rdata | output | W | Read data to the processor |
| pin_a_in | input | W | Port A pin sense |
| pin_b_in | input | W | Port B pin sense |
| pin_c_in | input | W | Port C pin sense |
| pin_a_out | output | W | Port A output latch |
| pin_b_out | output | W | Port B output latch |
| pin_c_out | output | W | Port C output latch |
| oe_a | output | W | Port A per-bit drive enable |
| oe_b | output | W | Port B per-bit drive enable |
| oe_c | output | W | Port C per-bit drive enable |

## Verification
The main function is tried with five command words: all inputs, all outputs, and three mixed settings that give the two halves of port C opposite directions. In each case the same port writes and the same pin patterns are applied. Because the written values and the pin values differ in every nibble, each readback shows whether that nibble came from the latch or from the pin, and whether a write was kept or dropped. Directed cases cover the reset state, a command word with bit 7 clear, latch clearing on a new command, a write with the chip deselected, idle and command-register reads, and reset applied mid-run.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CMD = 2'd3;

  localparam int CB_MODESET = 7;
  localparam int CB_A_IN    = 4;
  localparam int CB_CU_IN   = 3;
  localparam int CB_B_IN    = 1;
  localparam int CB_CL_IN   = 0;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

  function automatic dir_t decode_dir(input logic [7:0] w);
    dir_t d;
    d.a_in  = w[CB_A_IN];
    d.cu_in = w[CB_CU_IN];
    d.b_in  = w[CB_B_IN];
    d.cl_in = w[CB_CL_IN];
    return d;
  endfunction

  function automatic logic is_modeset(input logic [7:0] w);
    return w[CB_MODESET];
  endfunction
endpackage

// File: rtl/pio_dir_reg.sv
module pio_dir_reg
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] cmd,
  output dir_t       dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir <= DIR_RESET;
    else if (load) dir <= decode_dir(cmd);
  end
endmodule

// File: rtl/pio_port_latch.sv
module pio_port_latch #(
  parameter int W    = 8,
  parameter int SEGS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            we,
  input  logic [W-1:0]    d,
  input  logic [SEGS-1:0] seg_out,
  output logic [W-1:0]    q
);
  localparam int SEGW = W / SEGS;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q[s*SEGW +: SEGW] <= '0;
      else if (clr)               q[s*SEGW +: SEGW] <= '0;
      else if (we && seg_out[s])  q[s*SEGW +: SEGW] <= d[s*SEGW +: SEGW];
    end
  end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] pin_a,
  input  logic [W-1:0] pin_b,
  input  logic [W-1:0] pin_c,
  input  logic [W-1:0] lat_a,
  input  logic [W-1:0] lat_b,
  input  logic [W-1:0] lat_c,
  input  logic [W-1:0] out_a,
  input  logic [W-1:0] out_b,
  input  logic [W-1:0] out_c,
  output logic [W-1:0] rdata
);
  function automatic logic [W-1:0] blend(input logic [W-1:0] pin,
                                         input logic [W-1:0] lat,
                                         input logic [W-1:0] is_out);
    return (lat & is_out) | (pin & ~is_out);
  endfunction

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        SEL_A:   rdata = blend(pin_a, lat_a, out_a);
        SEL_B:   rdata = blend(pin_b, lat_b, out_b);
        SEL_C:   rdata = blend(pin_c, lat_c, out_c);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/triport_pio.sv
module triport_pio
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_a_in,
  input  logic [W-1:0] pin_b_in,
  input  logic [W-1:0] pin_c_in,
  output logic [W-1:0] pin_a_out,
  output logic [W-1:0] pin_b_out,
  output logic [W-1:0] pin_c_out,
  output logic [W-1:0] oe_a,
  output logic [W-1:0] oe_b,
  output logic [W-1:0] oe_c
);
  localparam int HALF = W / 2;

  // named internal events, used by the bound checker
  logic       acc_wr;
  logic       acc_rd;
  logic       cmd_wr;
  logic [2:0] port_we;
  dir_t       dir;

  assign acc_wr = !cs_n && !wr_n;
  assign acc_rd = !cs_n && !rd_n;
  assign cmd_wr = acc_wr && (addr == SEL_CMD) && is_modeset(wdata[7:0]);

  for (genvar p = 0; p < 3; p++) begin : g_we
    assign port_we[p] = acc_wr && (addr == 2'(p));
  end

  pio_dir_reg u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_wr),
    .cmd   (wdata[7:0]),
    .dir   (dir)
  );

  assign oe_a = {W{~dir.a_in}};
  assign oe_b = {W{~dir.b_in}};
  assign oe_c = {{HALF{~dir.cu_in}}, {HALF{~dir.cl_in}}};

  pio_port_latch #(.W(W), .SEGS(1)) u_lat_a (
    .clk (clk), .rst_n (rst_n), .clr (cmd_wr), .we (port_we[0]),
    .d (wdata), .seg_out (~dir.a_in), .q (pin_a_out)
  );

  pio_port_latch #(.W(W), .SEGS(1)) u_lat_b (
    .clk (clk), .rst_n (rst_n), .clr (cmd_wr), .we (port_we[1]),
    .d (wdata), .seg_out (~dir.b_in), .q (pin_b_out)
  );

  pio_port_latch #(.W(W), .SEGS(2)) u_lat_c (
    .clk (clk), .rst_n (rst_n), .clr (cmd_wr), .we (port_we[2]),
    .d (wdata), .seg_out ({~dir.cu_in, ~dir.cl_in}), .q (pin_c_out)
  );

  pio_rd_mux #(.W(W)) u_rd (
    .rd_en (acc_rd),
    .addr  (addr),
    .pin_a (pin_a_in), .pin_b (pin_b_in), .pin_c (pin_c_in),
    .lat_a (pin_a_out), .lat_b (pin_b_out), .lat_c (pin_c_out),
    .out_a (oe_a), .out_b (oe_b), .out_c (oe_c),
    .rdata (rdata)
  );
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] pin_a_out,
  input logic [W-1:0] pin_b_out,
  input logic [W-1:0] pin_c_out,
  input logic [W-1:0] oe_a,
  input logic [W-1:0] oe_b,
  input logic [W-1:0] oe_c,
  input logic         cmd_wr
);
  localparam int HALF = W / 2;

  // R1: deselected cycles leave all state alone
  a_r1_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(pin_a_out) && $stable(pin_b_out) && $stable(pin_c_out)
              && $stable(oe_a) && $stable(oe_b) && $stable(oe_c)));

  // R3: direction follows the command word
  a_r3_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (oe_a == {W{~$past(wdata[4])}}) && (oe_b == {W{~$past(wdata[1])}})
               && (oe_c[W-1:HALF] == {HALF{~$past(wdata[3])}})
               && (oe_c[HALF-1:0] == {HALF{~$past(wdata[0])}}));

  // R4: new command clears latches
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (pin_a_out == '0) && (pin_b_out == '0) && (pin_c_out == '0));

  // R5: command with bit 7 clear has no effect
  a_r5_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd3 && !wdata[7])
      |=> ($stable(oe_a) && $stable(oe_b) && $stable(oe_c)
           && $stable(pin_a_out) && $stable(pin_b_out) && $stable(pin_c_out)));

  // R6: output port write lands, input port write is dropped
  a_r6_write_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd1 && (&oe_b)) |=> pin_b_out == $past(wdata));

  a_r6_write_in: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'd1 && oe_b == '0) |=> $stable(pin_b_out));

  // R8: command register reads as zero
  a_r8_cmd_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == 2'd3) |-> rdata == '0);

  // R9: bus is quiet outside a read
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> rdata == '0);
endmodule

bind triport_pio pio_checker #(.W(W)) u_chk (.*);

// File: tb/tb_triport_pio.sv
`timescale 1ns/1ps
module tb_triport_pio;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pin_a_in = '0, pin_b_in = '0, pin_c_in = '0;
  logic [W-1:0] pin_a_out, pin_b_out, pin_c_out, oe_a, oe_b, oe_c;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  triport_pio #(.W(W)) dut (.*);

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] ra, rb, rc;
    logic [7:0] oa, ob, oc;
  } vec_t;

  // writes are 11h/22h/33h, pins are 3Ch/A5h/96h for every vector
  localparam vec_t VECS [5] = '{
    '{cmd: 8'h9B, ra: 8'h3C, rb: 8'hA5, rc: 8'h96, oa: 8'h00, ob: 8'h00, oc: 8'h00},
    '{cmd: 8'h80, ra: 8'h11, rb: 8'h22, rc: 8'h33, oa: 8'h11, ob: 8'h22, oc: 8'h33},
    '{cmd: 8'h88, ra: 8'h11, rb: 8'h22, rc: 8'h93, oa: 8'h11, ob: 8'h22, oc: 8'h03},
    '{cmd: 8'h91, ra: 8'h3C, rb: 8'h22, rc: 8'h36, oa: 8'h00, ob: 8'h22, oc: 8'h30},
    '{cmd: 8'h8A, ra: 8'h11, rb: 8'hA5, rc: 8'h93, oa: 8'h11, ob: 8'h00, oc: 8'h03}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1 v = rdata;
    #1 cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [23:0] exp_oe(input logic [7:0] c);
    logic [7:0] ea, eb, ec;
    ea = c[4] ? 8'h00 : 8'hFF;
    eb = c[1] ? 8'h00 : 8'hFF;
    ec = {c[3] ? 4'h0 : 4'hF, c[0] ? 4'h0 : 4'hF};
    return {ea, eb, ec};
  endfunction

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 oe after reset", {oe_a, oe_b, oe_c}, 24'h0);
    check("R2 latches after reset", {pin_a_out, pin_b_out, pin_c_out}, 24'h0);
    @(negedge clk) rst_n = 1'b1;
    pin_a_in = 8'h3C; pin_b_in = 8'hA5; pin_c_in = 8'h96;
    do_rd(2'd0, v);
    check("R7 reset read A from pins", v, 8'h3C);
    do_rd(2'd3, v);
    check("R8 command read", v, 8'h00);
    @(negedge clk) #1;
    check("R9 idle rdata", rdata, 8'h00);

    // table walk: R1 R3 R4 R6 R7 R10
    foreach (VECS[i]) begin
      do_wr(2'd3, VECS[i].cmd);
      check("R3 R10 oe from command", {oe_a, oe_b, oe_c}, exp_oe(VECS[i].cmd));
      do_wr(2'd0, 8'h11);
      do_wr(2'd1, 8'h22);
      do_wr(2'd2, 8'h33);
      check("R6 R10 latch A", pin_a_out, VECS[i].oa);
      check("R6 R10 latch B", pin_b_out, VECS[i].ob);
      check("R6 R10 latch C", pin_c_out, VECS[i].oc);
      do_rd(2'd0, v); check("R1 R7 read A", v, VECS[i].ra);
      do_rd(2'd1, v); check("R1 R7 read B", v, VECS[i].rb);
      do_rd(2'd2, v); check("R1 R7 read C", v, VECS[i].rc);
    end

    // R5: command with bit 7 clear ignored (state from last vector: 8Ah)
    do_wr(2'd3, 8'h1B);
    check("R5 oe unchanged", {oe_a, oe_b, oe_c}, exp_oe(8'h8A));
    check("R5 latches unchanged", {pin_a_out, pin_b_out, pin_c_out}, 24'h110003);

    // R1: write strobe with chip deselected
    @(negedge clk); addr = 2'd0; wdata = 8'hEE; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    check("R1 deselected write", pin_a_out, 8'h11);

    // R4: new command clears latches even with same directions
    do_wr(2'd3, 8'h8A);
    check("R4 latches cleared", {pin_a_out, pin_b_out, pin_c_out}, 24'h0);

    // R9: strobe low but chip deselected
    @(negedge clk); addr = 2'd1; rd_n = 1'b0; #1;
    check("R9 read without cs", rdata, 8'h00);
    rd_n = 1'b1;

    // R2: reset mid-run
    do_wr(2'd3, 8'h80);
    do_wr(2'd1, 8'h5A);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R2 oe after mid reset", {oe_a, oe_b, oe_c}, 24'h0);
    check("R2 latch after mid reset", pin_b_out, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule